// File: doc/BRIEF.md
# PCI Master-Abort Detection Timer

This block runs next to the sequencer of a PCI bus master. When the master starts a transaction, this block opens a fixed response window and watches DEVSEL#. If a target claims the cycle inside the window, the timer stops and nothing else happens. If no target responds, the block tells the sequencer to end the cycle. The sequencer first releases FRAME#, and it releases IRDY# one clock later. The block also returns a completion to the requester.

The command that was placed on C/BE# in the address phase is captured at the start. A Special Cycle is a broadcast command, so an abort on it is the expected outcome. That abort gives a normal completion and leaves no record. An abort on any other command gives an error completion and sets a sticky received-master-abort status bit. Software clears the bit with a write-one-to-clear strobe.

Top module: `pci_mabort_timer`

## Requirements
- R1: After reset, `abort_frame_rel`, `abort_irdy_rel`, `resp_valid`, `resp_err` and `rma_status` are all 0.
- R2: If `devsel_n` is sampled low at any of the five rising edges that follow the edge where `frame_start` is accepted, no abort is raised. No response is given and `rma_status` does not change.
- R3: If `devsel_n` stays high at all five of those edges, `abort_frame_rel` is 1 for exactly one cycle. That cycle comes right after the fifth edge.
- R4: `abort_irdy_rel` is 1 for exactly one cycle, in the cycle right after `abort_frame_rel`.
- R5: An abort on a command other than a Special Cycle gives a one-cycle `resp_valid` with `resp_err`=1, in the same cycle as `abort_irdy_rel`.
- R6: The Special Cycle command is C/BE# value 4'b0001. An abort on it gives a one-cycle `resp_valid` with `resp_err`=0 and leaves `rma_status` unchanged.
- R7: An abort on a command other than a Special Cycle sets `rma_status`. The bit is visible from the cycle of `abort_irdy_rel` onwards and stays at 1 until it is cleared.
- R8: A one-cycle `sts_clr` clears `rma_status` at the next edge. If a clear and a new logged abort land on the same edge, the bit ends at 1.
- R9: A `frame_start` that arrives while a transaction is being timed or aborted is ignored. A `devsel_n` low that arrives after the window has closed does not cancel the abort.
- R10: The command is captured on the edge where `frame_start` is accepted. Later changes of `cbe_cmd` do not affect that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse: the master asserts FRAME# (address phase) |
| cbe_cmd | input | 4 | C/BE# command value in the address phase |
| devsel_n | input | 1 | DEVSEL# from the bus, active low |
| sts_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| abort_frame_rel | output | 1 | Request to the sequencer to deassert FRAME# |
| abort_irdy_rel | output | 1 | Request to the sequencer to release IRDY# |
| resp_valid | output | 1 | Completion to the requester for an aborted cycle |
| resp_err | output | 1 | Completion is an error (valid with resp_valid) |
| rma_status | output | 1 | Sticky received-master-abort status |

## Verification
A window counter that is off by one shows up at the ports straight away. The frame-release pulse appears one cycle early or late against the fifth edge after FRAME#, or a claim on the fifth clock is missed. A command latch that is corrupted shows up in the completion cycle, one clock after the frame release, as a wrong `resp_err`. It shows up in the same cycle as a wrong `rma_status`. A status register with the wrong priority or a leaking clear shows up one edge after the clear or the abort.

// File: rtl/pci_mabort_pkg.sv
package pci_mabort_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FREL = 2'd2,
    ST_IREL = 2'd3
  } mab_state_e;

  localparam logic [3:0] CMD_SPECIAL_CYCLE = 4'b0001;

  // Broadcast command whose abort is expected and not recorded
  function automatic logic is_broadcast_cmd(input logic [3:0] cmd);
    return cmd == CMD_SPECIAL_CYCLE;
  endfunction

  // Next status value: a new logged abort beats a clear on the same edge
  function automatic logic next_sticky(input logic cur, input logic set,
                                       input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/pci_mabort_window.sv
module pci_mabort_window #(
  parameter int WINDOW = 5,
  localparam int CW = $clog2(WINDOW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          last
);

  function automatic logic at_limit(input logic [CW-1:0] c);
    return c == CW'(WINDOW);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= CW'(1);
    else if (run && !at_limit(cnt)) cnt <= cnt + CW'(1);
    else if (!run)   cnt <= '0;
  end

  assign last = run && at_limit(cnt);

endmodule

// File: rtl/pci_mabort_fsm.sv
module pci_mabort_fsm
  import pci_mabort_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [3:0] cbe_cmd,
  input  logic       devsel_n,
  input  logic       win_last,
  output logic       frame_acc,
  output logic       timing,
  output logic       claim_evt,
  output logic       miss_evt,
  output logic       log_evt,
  output logic       frel,
  output logic       irel,
  output logic       err_cpl
);

  mab_state_e st_q, st_d;
  logic       bcast_q;

  assign frame_acc = (st_q == ST_IDLE) && frame_start;
  assign timing    = (st_q == ST_WAIT);
  assign claim_evt = timing && !devsel_n;
  assign miss_evt  = timing && devsel_n && win_last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (frame_start) st_d = ST_WAIT;
      ST_WAIT: begin
        if (claim_evt)     st_d = ST_IDLE;
        else if (miss_evt) st_d = ST_FREL;
      end
      ST_FREL: st_d = ST_IREL;
      ST_IREL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bcast_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (frame_acc) bcast_q <= is_broadcast_cmd(cbe_cmd);
    end
  end

  assign frel    = (st_q == ST_FREL);
  assign irel    = (st_q == ST_IREL);
  assign log_evt = frel && !bcast_q;
  assign err_cpl = irel && !bcast_q;

endmodule

// File: rtl/pci_mabort_status.sv
module pci_mabort_status
  import pci_mabort_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic bit_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= next_sticky(bit_q, set, clr);
  end

endmodule

// File: rtl/pci_mabort_timer.sv
module pci_mabort_timer #(
  parameter int WINDOW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [3:0] cbe_cmd,
  input  logic       devsel_n,
  input  logic       sts_clr,
  output logic       abort_frame_rel,
  output logic       abort_irdy_rel,
  output logic       resp_valid,
  output logic       resp_err,
  output logic       rma_status
);

  localparam int CW = $clog2(WINDOW + 1);

  logic          frame_acc;
  logic          timing;
  logic          claim_evt;
  logic          miss_evt;
  logic          log_evt;
  logic          win_last;
  logic          frel;
  logic          irel;
  logic          err_cpl;
  logic [CW-1:0] win_cnt;

  pci_mabort_window #(.WINDOW(WINDOW)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .start (frame_acc),
    .run   (timing),
    .cnt   (win_cnt),
    .last  (win_last)
  );

  pci_mabort_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cbe_cmd     (cbe_cmd),
    .devsel_n    (devsel_n),
    .win_last    (win_last),
    .frame_acc   (frame_acc),
    .timing      (timing),
    .claim_evt   (claim_evt),
    .miss_evt    (miss_evt),
    .log_evt     (log_evt),
    .frel        (frel),
    .irel        (irel),
    .err_cpl     (err_cpl)
  );

  pci_mabort_status u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (log_evt),
    .clr   (sts_clr),
    .bit_q (rma_status)
  );

  assign abort_frame_rel = frel;
  assign abort_irdy_rel  = irel;
  assign resp_valid      = irel;
  assign resp_err        = err_cpl;

  logic unused_cnt;
  assign unused_cnt = ^win_cnt ^ miss_evt;

endmodule

// File: rtl/pci_mabort_chk.sv
module pci_mabort_chk #(
  parameter int WINDOW = 5
) (
  input logic clk,
  input logic rst_n,
  input logic frame_acc,
  input logic claim_evt,
  input logic sts_clr,
  input logic abort_frame_rel,
  input logic abort_irdy_rel,
  input logic resp_valid,
  input logic resp_err,
  input logic rma_status
);

  localparam int KW = $clog2(WINDOW + 3);
  logic [KW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n)                         since <= '0;
    else if (frame_acc)                 since <= KW'(1);
    else if (since != '0 && since <= KW'(WINDOW + 1)) since <= since + KW'(1);
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !abort_frame_rel && !resp_valid && !rma_status);

  a_r2_claim_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    claim_evt |=> !abort_frame_rel);

  a_r3_window_length: assert property (@(posedge clk) disable iff (!rst_n)
    abort_frame_rel |-> since == KW'(WINDOW + 1));

  a_r3_frel_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_frame_rel |=> !abort_frame_rel);

  a_r4_irdy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    abort_frame_rel |=> abort_irdy_rel);

  a_r5_resp_with_irdy: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> abort_irdy_rel);

  a_r6_special_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_err && !sts_clr) |=> $stable(rma_status));

  a_r7_rma_set: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> rma_status);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rma_status && !sts_clr) |=> rma_status);

endmodule

bind pci_mabort_timer pci_mabort_chk #(.WINDOW(WINDOW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .frame_acc       (frame_acc),
  .claim_evt       (claim_evt),
  .sts_clr         (sts_clr),
  .abort_frame_rel (abort_frame_rel),
  .abort_irdy_rel  (abort_irdy_rel),
  .resp_valid      (resp_valid),
  .resp_err        (resp_err),
  .rma_status      (rma_status)
);

// File: tb/pci_mabort_timer_tb.sv
module pci_mabort_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [3:0] cbe_cmd = 4'h0;
  logic       devsel_n = 1'b1;
  logic       sts_clr = 1'b0;
  logic       abort_frame_rel, abort_irdy_rel, resp_valid, resp_err, rma_status;

  int checks = 0;
  int fails  = 0;
  bit exp_rma = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_mabort_timer u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cbe_cmd(cbe_cmd),
    .devsel_n(devsel_n), .sts_clr(sts_clr), .abort_frame_rel(abort_frame_rel),
    .abort_irdy_rel(abort_irdy_rel), .resp_valid(resp_valid),
    .resp_err(resp_err), .rma_status(rma_status)
  );

  function automatic bit tb_aborts(input int claim_at);
    return !(claim_at >= 1 && claim_at <= 5);
  endfunction

  function automatic bit tb_special(input logic [3:0] cmd);
    return cmd == 4'b0001;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One transaction; claim_at 1..5 claims in window, 6 claims too late, else none
  task automatic run_txn(input logic [3:0] cmd, input int claim_at,
                         input bit clr_mid, input bit poke, input bit wiggle);
    bit ab, sp;
    ab = tb_aborts(claim_at);
    sp = tb_special(cmd);
    frame_start = 1'b1;
    cbe_cmd = cmd;
    @(negedge clk);
    frame_start = 1'b0;
    if (wiggle) cbe_cmd = cmd ^ 4'h1;   // R10
    for (int k = 1; k <= 5; k++) begin
      devsel_n = (claim_at == k) ? 1'b0 : 1'b1;
      frame_start = (poke && k == 2);   // R9
      if (poke && k == 2) cbe_cmd = cmd ^ 4'h1;
      chk("R2", "no frame release inside window", abort_frame_rel, 0);
      chk("R2", "no response inside window", resp_valid, 0);
      @(negedge clk);
    end
    frame_start = 1'b0;
    devsel_n = (claim_at == 6) ? 1'b0 : 1'b1;
    sts_clr = clr_mid;
    chk("R3", "frame release after fifth edge", abort_frame_rel, ab);
    chk("R4", "irdy release not yet", abort_irdy_rel, 0);
    @(negedge clk);
    devsel_n = 1'b1;
    sts_clr = 1'b0;
    if (ab && !sp) exp_rma = 1'b1;
    else if (clr_mid) exp_rma = 1'b0;
    chk("R4", "irdy release one clock after frame", abort_irdy_rel, ab);
    chk("R3", "frame release is one cycle", abort_frame_rel, 0);
    chk(sp ? "R6" : "R5", "resp_valid", resp_valid, ab);
    if (ab) chk(sp ? "R6" : "R5", "resp_err", resp_err, !sp);
    chk(clr_mid ? "R8" : "R7", "rma_status after abort", rma_status, exp_rma);
    @(negedge clk);
    chk("R4", "irdy release is one cycle", abort_irdy_rel, 0);
    chk("R5", "response is one cycle", resp_valid, 0);
    chk("R7", "rma_status sticky", rma_status, exp_rma);
  endtask

  task automatic clear_now();
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    exp_rma = 1'b0;
    chk("R8", "rma_status cleared", rma_status, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "abort_frame_rel at reset", abort_frame_rel, 0);
    chk("R1", "abort_irdy_rel at reset", abort_irdy_rel, 0);
    chk("R1", "resp_valid at reset", resp_valid, 0);
    chk("R1", "resp_err at reset", resp_err, 0);
    chk("R1", "rma_status at reset", rma_status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_txn(4'h1, 0, 0, 0, 0);          // R6 special abort, silent
    chk("R6", "special abort leaves status", rma_status, 0);
    run_txn(4'h7, 5, 0, 0, 0);          // R2 claim on last clock
    run_txn(4'h7, 1, 0, 0, 0);          // R2 claim on first clock
    run_txn(4'h6, 6, 0, 0, 0);          // R9 late DEVSEL, R5, R7
    run_txn(4'h1, 0, 0, 0, 0);          // R6 special does not disturb set bit
    clear_now();                        // R8
    run_txn(4'h6, 0, 0, 0, 0);
    run_txn(4'h3, 0, 1, 0, 0);          // R8 clear and set same edge
    clear_now();
    run_txn(4'h1, 0, 0, 0, 1);          // R10 special kept after cbe change
    run_txn(4'h0, 0, 0, 0, 1);          // R10 non-special kept
    clear_now();
    run_txn(4'h1, 0, 0, 1, 0);          // R9 poke ignored while timing
    run_txn(4'hA, 3, 0, 1, 0);          // R9 poke ignored, claim wins

    // Random mix
    for (int n = 0; n < 60; n++) begin
      logic [3:0] c;
      int ca;
      c  = ($urandom % 3 == 0) ? 4'h1 : 4'($urandom % 16);
      ca = int'($urandom % 8);
      run_txn(c, ca, bit'($urandom % 4 == 0), bit'(ca != 1 && $urandom % 5 == 0),
              bit'($urandom % 4 == 0));
      if ($urandom % 6 == 0) clear_now();
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule